// File: doc/BRIEF.md
# Dual-Rate Serial Word Receiver (ARINC 429 style)

This block takes one ARINC 429 style serial channel, presented as two digital rails: the "one" rail high for a logic 1, the "zero" rail high for a logic 0, and both rails low for the null that separates bits. The line is sampled ten times per bit. A configuration bit picks the bit rate: the master clock divided by 10 (a sample on every clock) or divided by 80 (a sample every eighth clock). A bit is taken once the same non-null rail has been seen on two samples in a row. Bits collect into a 32-bit or a 25-bit word, and a long null in the middle of a word drops the partial word.

For each finished word the block works out a parity status. In 32-bit mode it can also compare the two source/destination bits with a programmed code. An accepted word is shuffled into two 16-bit halves, stored in a holding register, and a ready flag is raised. A host reads a half by driving a select line and raising a read strobe. Either half can be read first and as often as needed. A strobe on the second half clears the ready flag. A self-test pair of rails can take the place of the line rails.

Top module: `a429_receiver`

## Requirements
- R1: With `cfg_slow_rate`=0 the line is sampled on every clock (bit time 10 clocks). With 1 it is sampled once every 8 clocks (bit time 80 clocks), so a rail level shorter than 8 clocks never yields a bit.
- R2: Rail code {hi,lo}: 10 is a 1, 01 is a 0, and 00 or 11 is null. A bit is taken when the same non-null code is seen on two consecutive samples, at most once per pulse. A level lasting a single sample is not a bit.
- R3: The first received bit is word bit 1. A word is complete after 32 bits when `cfg_short_word`=0 and after 25 bits when it is 1.
- R4: Parity status is 1 when the complete word holds an even number of ones and 0 when it holds an odd number. It appears at `rd_data[8]` of half 1.
- R5: In 32-bit mode with `cfg_filter_en`=1, a word is accepted only if bit 9 equals `cfg_match_x` and bit 10 equals `cfg_match_y`. Otherwise it is dropped: the ready flag and the stored halves are unchanged. With `cfg_filter_en`=0 every complete word is accepted.
- R6: In 25-bit mode every complete word is accepted, whatever the filter settings.
- R7: An accepted word replaces the stored halves and sets `word_ready`, even if the previous word was never read.
- R8: 32-bit layout. Half 1 = {bits 13,12,11,10,9, bits 31,30, parity status, bits 8..1}, with bit 1 at `rd_data[0]`. Half 2 = bits 29 down to 14, with bit 29 at `rd_data[15]`.
- R9: 25-bit layout. Half 1 = {seven zeros, parity status, bits 8..1}. Half 2 = bits 24 down to 9, with bit 24 at `rd_data[15]` and bit 9 at `rd_data[0]`.
- R10: While `rd_en`=1, `rd_data` shows half 1 for `rd_sel`=0 and half 2 for `rd_sel`=1, and it is zero while `rd_en`=0. A clock with `rd_en`=1 and `rd_sel`=1 clears `word_ready`. Reads with `rd_sel`=0 leave it set.
- R11: A run of 20 null samples after at least one bit of a word discards the partial word, and the next bit starts a new word.
- R12: With `cfg_self_test`=1 the receiver takes its input from `st_hi`/`st_lo` and ignores the line rails.
- R13: `rst_n` low clears the ready flag, the stored halves and the bit count. When a word is accepted in the same clock as a second-half read, `word_ready` ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low master reset |
| cfg_slow_rate | input | 1 | 0: bit = 10 clocks, 1: bit = 80 clocks |
| cfg_short_word | input | 1 | 0: 32-bit word, 1: 25-bit word |
| cfg_filter_en | input | 1 | Enable source/destination match |
| cfg_match_x | input | 1 | Required value of word bit 9 |
| cfg_match_y | input | 1 | Required value of word bit 10 |
| cfg_self_test | input | 1 | Take input from the self-test rails |
| line_hi | input | 1 | Line "one" rail |
| line_lo | input | 1 | Line "zero" rail |
| st_hi | input | 1 | Self-test "one" rail |
| st_lo | input | 1 | Self-test "zero" rail |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Half select: 0 half 1, 1 half 2 |
| rd_data | output | 16 | Selected half while `rd_en` is high, else zero |
| word_ready | output | 1 | An accepted word is waiting |

## Verification
The ready flag has two causes that can land on the same clock: a newly accepted word sets it and a second-half read clears it. The bench places a one-clock second-half read exactly on the clock where the last bit of a word is being latched. It counts the sample clocks from the final rail level to find that clock. It then expects `word_ready` still high and the new halves readable. Filter drops are judged by reading back the previous halves unchanged, and the break rule by receiving a clean word right after a truncated one.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    localparam int HALF_W = 16;

    // Rail pair code {one_rail, zero_rail}
    typedef enum logic [1:0] {
        RAIL_NULL = 2'b00,
        RAIL_ZERO = 2'b01,
        RAIL_ONE  = 2'b10,
        RAIL_BAD  = 2'b11
    } rail_e;

    typedef struct packed {
        logic [HALF_W-1:0] hw1;
        logic [HALF_W-1:0] hw2;
    } halves_t;

endpackage

// File: rtl/a429_rx_sampler.sv
module a429_rx_sampler
    import a429_rx_pkg::*;
#(
    parameter int SLOW_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_i,
    input  logic [1:0] rail_i,
    output logic       tick_o,
    output logic       null_o,
    output logic       bit_stb_o,
    output logic       bit_val_o
);

    localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        rail_e            prev;
        logic             armed;
    } smp_t;

    smp_t  s_d, s_q;
    rail_e cur;

    always_comb begin
        s_d       = s_q;
        cur       = rail_e'(rail_i);
        null_o    = (cur == RAIL_NULL) || (cur == RAIL_BAD);
        bit_val_o = (cur == RAIL_ONE);
        bit_stb_o = 1'b0;
        tick_o    = slow_i ? (s_q.div == DIV_W'(SLOW_DIV - 1)) : 1'b1;

        if (slow_i) begin
            s_d.div = tick_o ? '0 : s_q.div + DIV_W'(1);
        end else begin
            s_d.div = '0;
        end

        if (tick_o) begin
            s_d.prev = cur;
            if (null_o) begin
                s_d.armed = 1'b1;
            end else if ((cur == s_q.prev) && s_q.armed) begin
                bit_stb_o = 1'b1;
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{div: '0, prev: RAIL_NULL, armed: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    AST_SLOW_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_i && tick_o) |=> (!tick_o || !slow_i)); // R1

    AST_ONE_BIT_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o); // R2

endmodule

// File: rtl/a429_rx_assembler.sv
module a429_rx_assembler #(
    parameter int WORD_MAX      = 32,
    parameter int WORD_MIN      = 25,
    parameter int BREAK_SAMPLES = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                short_i,
    input  logic                tick_i,
    input  logic                null_i,
    input  logic                bit_stb_i,
    input  logic                bit_val_i,
    output logic                done_o,
    output logic [WORD_MAX-1:0] word_o
);

    localparam int CNT_W = $clog2(WORD_MAX + 1);
    localparam int IDX_W = $clog2(WORD_MAX);
    localparam int RUN_W = $clog2(BREAK_SAMPLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [WORD_MAX-1:0] word;
        logic [RUN_W-1:0]    run;
        logic                done;
    } asm_t;

    asm_t             a_d, a_q;
    logic [CNT_W-1:0] len;

    always_comb begin
        a_d      = a_q;
        a_d.done = 1'b0;
        len      = short_i ? CNT_W'(WORD_MIN) : CNT_W'(WORD_MAX);

        if (tick_i && null_i) begin
            if (a_q.run != RUN_W'(BREAK_SAMPLES)) begin
                a_d.run = a_q.run + RUN_W'(1);
            end
            if (a_q.run == RUN_W'(BREAK_SAMPLES - 1)) begin
                a_d.cnt = '0;
            end
        end else if (tick_i) begin
            a_d.run = '0;
        end

        if (bit_stb_i) begin
            if (a_q.cnt == '0) begin
                a_d.word = '0;
            end
            a_d.word[a_q.cnt[IDX_W-1:0]] = bit_val_i;
            if (a_q.cnt + CNT_W'(1) >= len) begin
                a_d.cnt  = '0;
                a_d.done = 1'b1;
            end else begin
                a_d.cnt = a_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign done_o = a_q.done;
    assign word_o = a_q.word;

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.cnt < CNT_W'(WORD_MAX)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.done |=> !a_q.done); // R3

    AST_BREAK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q.run == RUN_W'(BREAK_SAMPLES)) |-> (a_q.cnt == '0)); // R11

endmodule

// File: rtl/a429_rx_format.sv
module a429_rx_format
    import a429_rx_pkg::*;
#(
    parameter int WORD_MAX = 32,
    parameter int WORD_MIN = 25
) (
    input  logic [WORD_MAX-1:0] word_i,
    input  logic                short_i,
    input  logic                filt_en_i,
    input  logic                x_i,
    input  logic                y_i,
    output halves_t             halves_o,
    output logic                keep_o
);

    localparam int LABEL_W  = 8;
    localparam int SD_LO    = 8;   // index of word bit 9
    localparam int SD_HI    = 9;   // index of word bit 10
    localparam int HW1_TOP  = 12;  // index of word bit 13
    localparam int SSM_HI   = 30;  // index of word bit 31
    localparam int SSM_LO   = 29;  // index of word bit 30
    localparam int L_HW2_LO = 13;  // index of word bit 14
    localparam int S_HW2_LO = 8;   // index of word bit 9

    logic par_even;

    always_comb begin
        par_even = short_i ? ~(^word_i[WORD_MIN-1:0]) : ~(^word_i);
        keep_o   = short_i || !filt_en_i ||
                   ((word_i[SD_LO] == x_i) && (word_i[SD_HI] == y_i));
        if (short_i) begin
            halves_o.hw1 = {7'b0, par_even, word_i[LABEL_W-1:0]};
            halves_o.hw2 = word_i[S_HW2_LO + HALF_W - 1 : S_HW2_LO];
        end else begin
            halves_o.hw1 = {word_i[HW1_TOP:SD_LO], word_i[SSM_HI:SSM_LO],
                            par_even, word_i[LABEL_W-1:0]};
            halves_o.hw2 = word_i[L_HW2_LO + HALF_W - 1 : L_HW2_LO];
        end
    end

endmodule

// File: rtl/a429_receiver.sv
module a429_receiver
    import a429_rx_pkg::*;
#(
    parameter int SLOW_DIV      = 8,
    parameter int WORD_MAX      = 32,
    parameter int WORD_MIN      = 25,
    parameter int BREAK_SAMPLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_slow_rate,
    input  logic        cfg_short_word,
    input  logic        cfg_filter_en,
    input  logic        cfg_match_x,
    input  logic        cfg_match_y,
    input  logic        cfg_self_test,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        st_hi,
    input  logic        st_lo,
    input  logic        rd_en,
    input  logic        rd_sel,
    output logic [15:0] rd_data,
    output logic        word_ready
);

    typedef struct packed {
        halves_t hold;
        logic    ready;
    } top_t;

    top_t                t_d, t_q;
    logic [1:0]          rail;
    logic                tick, smp_null, bit_stb, bit_val;
    logic                done;
    logic [WORD_MAX-1:0] word;
    halves_t             fmt;
    logic                keep;
    logic                accept;

    assign rail = cfg_self_test ? {st_hi, st_lo} : {line_hi, line_lo};

    a429_rx_sampler #(.SLOW_DIV(SLOW_DIV)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_i    (cfg_slow_rate),
        .rail_i    (rail),
        .tick_o    (tick),
        .null_o    (smp_null),
        .bit_stb_o (bit_stb),
        .bit_val_o (bit_val)
    );

    a429_rx_assembler #(
        .WORD_MAX      (WORD_MAX),
        .WORD_MIN      (WORD_MIN),
        .BREAK_SAMPLES (BREAK_SAMPLES)
    ) u_assembler (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_i   (cfg_short_word),
        .tick_i    (tick),
        .null_i    (smp_null),
        .bit_stb_i (bit_stb),
        .bit_val_i (bit_val),
        .done_o    (done),
        .word_o    (word)
    );

    a429_rx_format #(.WORD_MAX(WORD_MAX), .WORD_MIN(WORD_MIN)) u_format (
        .word_i    (word),
        .short_i   (cfg_short_word),
        .filt_en_i (cfg_filter_en),
        .x_i       (cfg_match_x),
        .y_i       (cfg_match_y),
        .halves_o  (fmt),
        .keep_o    (keep)
    );

    always_comb begin
        t_d    = t_q;
        accept = done && keep;
        if (accept) begin
            t_d.hold  = fmt;
            t_d.ready = 1'b1;
        end else if (rd_en && rd_sel) begin
            t_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign word_ready = t_q.ready;
    assign rd_data    = !rd_en ? '0 : (rd_sel ? t_q.hold.hw2 : t_q.hold.hw1);

    AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> word_ready); // R7

    AST_HOLD_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(t_q.hold)); // R7

    AST_SECOND_HALF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && !accept) |=> !word_ready); // R10

    AST_FIRST_HALF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && rd_en && !rd_sel) |=> word_ready); // R10

    AST_FILTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_filter_en && !cfg_short_word && (word[8] != cfg_match_x))
        |=> $stable(t_q.hold)); // R5

endmodule

// File: tb/a429_receiver_bench.sv
module a429_receiver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_slow_rate = 1'b0, cfg_short_word = 1'b0, cfg_filter_en = 1'b0;
    logic        cfg_match_x = 1'b0, cfg_match_y = 1'b0, cfg_self_test = 1'b0;
    logic        line_hi = 1'b0, line_lo = 1'b0, st_hi = 1'b0, st_lo = 1'b0;
    logic        rd_en = 1'b0, rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        word_ready;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    a429_receiver u_a429_receiver (
        .clk(clk), .rst_n(rst_n), .cfg_slow_rate(cfg_slow_rate),
        .cfg_short_word(cfg_short_word), .cfg_filter_en(cfg_filter_en),
        .cfg_match_x(cfg_match_x), .cfg_match_y(cfg_match_y),
        .cfg_self_test(cfg_self_test), .line_hi(line_hi), .line_lo(line_lo),
        .st_hi(st_hi), .st_lo(st_lo), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .word_ready(word_ready)
    );

    // {short, filter_en, x, y, word[31:0], expect_accept}
    localparam logic [36:0] VECS [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 32'h8A5C_3E71, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_5165, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_5365, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b0, 32'h01AB_CDEF, 1'b1},
        {1'b1, 1'b0, 1'b0, 1'b0, 32'h0155_0F0F, 1'b1},
        {1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FAFF, 1'b1}
    };

    function automatic logic [15:0] exp_hw1(input logic [31:0] w, input logic s);
        logic p;
        p = s ? ~(^w[24:0]) : ~(^w);
        return s ? {7'b0, p, w[7:0]} : {w[12:8], w[30:29], p, w[7:0]};
    endfunction

    function automatic logic [15:0] exp_hw2(input logic [31:0] w, input logic s);
        return s ? w[23:8] : w[28:13];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_rails(input logic hi, input logic lo, input bit use_st);
        if (use_st) begin st_hi = hi; st_lo = lo; end
        else begin line_hi = hi; line_lo = lo; end
    endtask

    task automatic send_word(input logic [31:0] w, input int nbits, input int lvl,
                             input int nul, input int gap, input bit use_st,
                             input bit strobe_last);
        for (int i = 0; i < nbits; i++) begin
            set_rails(w[i], ~w[i], use_st);
            if (strobe_last && i == nbits - 1) begin
                repeat (2) @(negedge clk);
                rd_sel = 1'b1; rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0; rd_sel = 1'b0;
                repeat (2) @(negedge clk);
            end else begin
                repeat (lvl) @(negedge clk);
            end
            set_rails(1'b0, 1'b0, use_st);
            repeat (nul) @(negedge clk);
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic read_half(input logic sel, output logic [15:0] d);
        @(negedge clk);
        rd_sel = sel; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 1'b0;
    endtask

    task automatic drain;
        logic [15:0] d;
        read_half(1'b1, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d, last1, last2;
        logic [31:0] w;
        logic s;

        // Reset state (R13)
        repeat (3) @(negedge clk);
        chk("R13 ready in reset", {31'b0, word_ready}, 32'd0);
        rd_en = 1'b1; #1;
        chk("R13 hold cleared", {16'b0, rd_data}, 32'd0);
        rd_en = 1'b0; #1;
        chk("R10 idle bus zero", {16'b0, rd_data}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        last1 = '0; last2 = '0;

        // Table walk: fast rate (R3 R4 R5 R6 R7 R8 R9 R10)
        for (int v = 0; v < 6; v++) begin
            s = VECS[v][36];
            w = VECS[v][32:1];
            cfg_short_word = s; cfg_filter_en = VECS[v][35];
            cfg_match_x = VECS[v][34]; cfg_match_y = VECS[v][33];
            send_word(w, s ? 25 : 32, 5, 5, 40, 1'b0, 1'b0);
            chk(VECS[v][0] ? "R7 ready after accept" : "R5 ready after drop",
                {31'b0, word_ready}, {31'b0, VECS[v][0]});
            read_half(1'b0, d);
            chk(s ? "R9 R4 half1" : "R8 R4 half1", {16'b0, d},
                {16'b0, VECS[v][0] ? exp_hw1(w, s) : last1});
            read_half(1'b0, d);
            chk("R10 half1 repeat", {16'b0, d},
                {16'b0, VECS[v][0] ? exp_hw1(w, s) : last1});
            chk("R10 half1 keeps ready", {31'b0, word_ready}, {31'b0, VECS[v][0]});
            read_half(1'b1, d);
            chk(s ? "R9 half2" : "R8 half2", {16'b0, d},
                {16'b0, VECS[v][0] ? exp_hw2(w, s) : last2});
            chk("R10 half2 clears ready", {31'b0, word_ready}, 32'd0);
            if (VECS[v][0]) begin last1 = exp_hw1(w, s); last2 = exp_hw2(w, s); end
        end
        cfg_filter_en = 1'b0; cfg_short_word = 1'b0;

        // Overwrite of an unread word (R7)
        send_word(32'h0F0F_A5A5, 32, 5, 5, 40, 1'b0, 1'b0);
        send_word(32'h7E81_1C3D, 32, 5, 5, 40, 1'b0, 1'b0);
        read_half(1'b1, d);
        chk("R7 overwrite half2", {16'b0, d}, {16'b0, exp_hw2(32'h7E81_1C3D, 1'b0)});

        // Single-sample pulses are not bits (R2)
        send_word(32'hFFFF_FFFF, 32, 1, 9, 40, 1'b0, 1'b0);
        chk("R2 one-sample pulses", {31'b0, word_ready}, 32'd0);

        // Slow rate (R1)
        cfg_slow_rate = 1'b1;
        send_word(32'hC3A5_9617, 32, 7, 73, 40, 1'b0, 1'b0);
        chk("R1 short pulses at slow rate", {31'b0, word_ready}, 32'd0);
        send_word(32'hC3A5_9617, 32, 40, 40, 320, 1'b0, 1'b0);
        chk("R1 slow word ready", {31'b0, word_ready}, 32'd1);
        read_half(1'b0, d);
        chk("R1 slow half1", {16'b0, d}, {16'b0, exp_hw1(32'hC3A5_9617, 1'b0)});
        read_half(1'b1, d);
        chk("R1 slow half2", {16'b0, d}, {16'b0, exp_hw2(32'hC3A5_9617, 1'b0)});
        cfg_slow_rate = 1'b0;

        // Broken word then a clean one (R11)
        send_word(32'hFFFF_FFFF, 20, 5, 5, 30, 1'b0, 1'b0);
        chk("R11 partial not ready", {31'b0, word_ready}, 32'd0);
        send_word(32'h2468_ACE1, 32, 5, 5, 40, 1'b0, 1'b0);
        read_half(1'b0, d);
        chk("R11 clean half1", {16'b0, d}, {16'b0, exp_hw1(32'h2468_ACE1, 1'b0)});
        read_half(1'b1, d);
        chk("R11 clean half2", {16'b0, d}, {16'b0, exp_hw2(32'h2468_ACE1, 1'b0)});

        // Self-test input (R12)
        cfg_self_test = 1'b1;
        send_word(32'h9ABC_DEF0, 32, 5, 5, 40, 1'b0, 1'b0);
        chk("R12 line ignored", {31'b0, word_ready}, 32'd0);
        send_word(32'h9ABC_DEF0, 32, 5, 5, 40, 1'b1, 1'b0);
        read_half(1'b0, d);
        chk("R12 self-test half1", {16'b0, d}, {16'b0, exp_hw1(32'h9ABC_DEF0, 1'b0)});
        drain();
        cfg_self_test = 1'b0;

        // Accept coinciding with a second-half read (R13)
        send_word(32'h5566_7788, 32, 5, 5, 40, 1'b0, 1'b1);
        chk("R13 accept wins over clear", {31'b0, word_ready}, 32'd1);
        read_half(1'b1, d);
        chk("R13 coincident half2", {16'b0, d}, {16'b0, exp_hw2(32'h5566_7788, 1'b0)});

        // Reset clears ready (R13)
        send_word(32'h1357_9BDF, 32, 5, 5, 40, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R13 reset clears ready", {31'b0, word_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule